// File: doc/BRIEF.md
# Jitter Bit Sequencer

This block runs the per-bit control sequence of a jitter-based random bit source. When a request arrives, it opens a start window on a system-clock edge. The window is therefore aligned to the clock in the same way for every bit, so clock interference is the same each time. While the window is open, the block:
- enables the slow oscillator at once;
- enables the fast oscillator only after the external compensation delay reports back;
- counts a programmable number N of slow-oscillator ticks to mark the sampling instant.

When the window closes, both oscillators stop and the sampled value moves into the output register. A one-cycle valid pulse flags the new bit. The sampler and the ring-length LFSR are held in reset whenever no window is open. Each bit therefore starts from the same state and carries no memory of earlier bits. The oscillators, the delay line and the sampler sit outside this block.

A request that arrives during a window is remembered. Its bit starts right after the current one finishes. N is latched when a window opens, so it can only change between bits.

Top module: `jbit_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, startWin, slowEn, fastEn, sampleStrobe, bitValid and rndBit are 0, and lfsrRst and samplerRst are 1.
- R2: A request sampled in idle opens startWin in the next cycle. The window stays high for exactly windowLen cycles. A windowLen of 0 acts as 1.
- R3: slowEn always equals startWin. lfsrRst and samplerRst are high whenever startWin is low, and low whenever it is high.
- R4: fastEn rises in the cycle after fastAck is sampled high inside a window. It stays high until the window closes. fastAck outside a window has no effect.
- R5: sampleStrobe is a one-cycle pulse in the cycle after the edge that samples the N-th slowTick of a window. It occurs at most once per window. N=0 acts as 1. slowTick outside a window is not counted.
- R6: N is taken from divSel at the edge that opens the window. Changes to divSel during the window have no effect on that bit.
- R7: At the edge that closes the window, rndBit takes samplerIn. bitValid is high for exactly the first cycle after the window.
- R8: rndBit changes only at a capture. samplerIn outside that edge has no effect.
- R9: A request seen during a window is held. The next window opens after exactly one cycle with startWin low. Several requests in one window yield one extra bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitReq | input | 1 | Request for one bit |
| divSel | input | N_W | Prescale factor N |
| windowLen | input | WIN_W | Window length in system clocks |
| slowTick | input | 1 | One pulse per slow-oscillator period, clock-synchronous |
| fastAck | input | 1 | Delayed fast-enable has arrived |
| samplerIn | input | 1 | Output of the sampling flip-flop |
| startWin | output | 1 | Start window |
| slowEn | output | 1 | Slow oscillator enable |
| fastEn | output | 1 | Fast oscillator enable |
| lfsrRst | output | 1 | Ring-length LFSR reset |
| samplerRst | output | 1 | Sampling flip-flop reset |
| sampleStrobe | output | 1 | Sampling instant after N slow ticks |
| rndBit | output | 1 | Captured bit |
| bitValid | output | 1 | One-cycle flag for a new bit |

## Verification
Every output comes from a register, so each result is due one clock after the edge that samples its cause:
- startWin and slowEn follow the request edge by one cycle;
- fastEn follows the fastAck edge by one cycle;
- sampleStrobe follows the edge of the N-th tick by one cycle;
- rndBit and bitValid appear in the first cycle after the window.

The bench drives and samples two time units after each rising edge. It checks the expected value cycle by cycle across the whole window. A queued bit is checked to open after exactly one low cycle.

// File: rtl/jbit_pkg.sv
package jbit_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  typedef struct packed {
    logic startBit;   // window opens at this edge
    logic active;     // window is open
    logic capture;    // window closes at this edge
  } seqStrobe_t;
endpackage

// File: rtl/jbit_ctrl.sv
module jbit_ctrl
  import jbit_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitReq,
  input  logic [WIN_W-1:0] windowLen,
  output seqStrobe_t       strb
);
  seqState_t        state;
  logic [WIN_W-1:0] winCnt;
  logic             pending;
  logic [WIN_W-1:0] winLoad;

  assign winLoad = (windowLen == '0) ? '0 : windowLen - 1'b1;

  always_comb begin
    strb.active   = (state == ST_RUN);
    strb.startBit = (state == ST_IDLE) && (bitReq || pending);
    strb.capture  = (state == ST_RUN) && (winCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      pending <= 1'b0;
    end else begin
      if (strb.startBit) pending <= 1'b0;
      else if (bitReq && state == ST_RUN) pending <= 1'b1;
      case (state)
        ST_IDLE: if (strb.startBit) begin
          state  <= ST_RUN;
          winCnt <= winLoad;
        end
        ST_RUN: begin
          if (winCnt == '0) state <= ST_IDLE;
          else winCnt <= winCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CAPTURE_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.active); // R2
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    strb.startBit |=> strb.active); // R9
endmodule

// File: rtl/jbit_dpath.sv
module jbit_dpath
  import jbit_pkg::*;
#(
  parameter int N_W = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobe_t     strb,
  input  logic [N_W-1:0] divSel,
  input  logic           slowTick,
  input  logic           fastAck,
  input  logic           samplerIn,
  output logic           sampleStrobe,
  output logic           fastEn,
  output logic           rndBit,
  output logic           bitValid
);
  localparam int CW = N_W + 1;

  logic [N_W-1:0] nHold;
  logic [N_W-1:0] tickCnt;
  logic           done;
  logic [CW-1:0]  nextCnt;

  assign nextCnt = {1'b0, tickCnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nHold        <= '0;
      tickCnt      <= '0;
      done         <= 1'b0;
      sampleStrobe <= 1'b0;
      fastEn       <= 1'b0;
      rndBit       <= 1'b0;
      bitValid     <= 1'b0;
    end else begin
      sampleStrobe <= 1'b0;
      bitValid     <= 1'b0;
      if (strb.startBit) begin
        nHold   <= divSel;
        tickCnt <= '0;
        done    <= 1'b0;
      end else if (strb.active && slowTick && !done) begin
        if (nextCnt >= {1'b0, nHold}) begin
          sampleStrobe <= 1'b1;
          done         <= 1'b1;
        end else begin
          tickCnt <= nextCnt[N_W-1:0];
        end
      end
      if (strb.capture) begin
        fastEn   <= 1'b0;
        rndBit   <= samplerIn;
        bitValid <= 1'b1;
      end else if (strb.active && fastAck) begin
        fastEn <= 1'b1;
      end
    end
  end

  AST_FAST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    fastEn |-> strb.active); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid); // R7
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rndBit)); // R8
endmodule

// File: rtl/jbit_sequencer.sv
module jbit_sequencer
  import jbit_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int N_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitReq,
  input  logic [N_W-1:0]   divSel,
  input  logic [WIN_W-1:0] windowLen,
  input  logic             slowTick,
  input  logic             fastAck,
  input  logic             samplerIn,
  output logic             startWin,
  output logic             slowEn,
  output logic             fastEn,
  output logic             lfsrRst,
  output logic             samplerRst,
  output logic             sampleStrobe,
  output logic             rndBit,
  output logic             bitValid
);
  seqStrobe_t strb;

  jbit_ctrl #(.WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitReq(bitReq), .windowLen(windowLen), .strb(strb)
  );

  jbit_dpath #(.N_W(N_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .divSel(divSel),
    .slowTick(slowTick), .fastAck(fastAck), .samplerIn(samplerIn),
    .sampleStrobe(sampleStrobe), .fastEn(fastEn), .rndBit(rndBit),
    .bitValid(bitValid)
  );

  assign startWin   = strb.active;
  assign slowEn     = strb.active;
  assign lfsrRst    = ~strb.active;
  assign samplerRst = ~strb.active;

  AST_RESETS_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    !startWin |-> (lfsrRst && samplerRst && !fastEn)); // R3
endmodule

// File: tb/jbit_sequencer_tb.sv
module jbit_sequencer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitReq = 1'b0;
  logic [5:0] divSel = 6'd1;
  logic [7:0] windowLen = 8'd4;
  logic slowTick = 1'b0, fastAck = 1'b0, samplerIn = 1'b0;
  logic startWin, slowEn, fastEn, lfsrRst, samplerRst, sampleStrobe, rndBit, bitValid;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  jbit_sequencer u_dut (
    .clk(clk), .rstN(rstN), .bitReq(bitReq), .divSel(divSel), .windowLen(windowLen),
    .slowTick(slowTick), .fastAck(fastAck), .samplerIn(samplerIn),
    .startWin(startWin), .slowEn(slowEn), .fastEn(fastEn), .lfsrRst(lfsrRst),
    .samplerRst(samplerRst), .sampleStrobe(sampleStrobe), .rndBit(rndBit),
    .bitValid(bitValid)
  );

  task automatic chk(input int act, input int exp, input string msg);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // request is sampled at the next edge; returns with the window open
  task automatic request();
    bitReq = 1'b1; tick(); bitReq = 1'b0;
  endtask

  task automatic tReset();
    tick(); tick();
    chk(startWin, 0, "R1 startWin"); chk(slowEn, 0, "R1 slowEn");
    chk(fastEn, 0, "R1 fastEn"); chk(sampleStrobe, 0, "R1 sampleStrobe");
    chk(bitValid, 0, "R1 bitValid"); chk(rndBit, 0, "R1 rndBit");
    chk(lfsrRst, 1, "R1 lfsrRst"); chk(samplerRst, 1, "R1 samplerRst");
    rstN = 1'b1; tick();
    chk(startWin, 0, "R1 startWin after release");
  endtask

  task automatic tWindow(input int len);
    int eff = (len == 0) ? 1 : len;
    windowLen = len[7:0];
    request();
    for (int i = 0; i < eff; i++) begin
      chk(startWin, 1, $sformatf("R2 startWin len %0d cycle %0d", len, i));
      chk(slowEn, 1, "R3 slowEn in window");
      chk(lfsrRst | samplerRst, 0, "R3 resets released in window");
      tick();
    end
    chk(startWin, 0, $sformatf("R2 window closed len %0d", len));
    chk(lfsrRst & samplerRst & ~slowEn, 1, "R3 resets held after window");
    chk(bitValid, 1, "R7 bitValid first idle cycle");
    tick();
    chk(bitValid, 0, "R7 bitValid one cycle");
  endtask

  task automatic tPrescale(input int n, input int len);
    int expIdx = (n == 0) ? 1 : n;
    // ticks while idle must not count
    slowTick = 1'b1; tick(); tick(); tick();
    chk(sampleStrobe, 0, "R5 idle ticks ignored");
    slowTick = 1'b0;
    windowLen = len[7:0]; divSel = n[5:0];
    request();
    divSel = 6'd63;          // change after latch: ignored
    slowTick = 1'b1;
    for (int i = 0; i < len; i++) begin
      chk(sampleStrobe, (i == expIdx) ? 1 : 0,
          $sformatf("R5 R6 strobe N %0d cycle %0d", n, i));
      tick();
    end
    slowTick = 1'b0; tick();
  endtask

  task automatic tFast();
    fastAck = 1'b1; tick(); tick();
    chk(fastEn, 0, "R4 fastAck while idle ignored");
    fastAck = 1'b0;
    windowLen = 8'd6;
    request();
    for (int i = 0; i < 6; i++) begin
      chk(fastEn, (i >= 3) ? 1 : 0, $sformatf("R4 fastEn cycle %0d", i));
      fastAck = (i == 2);
      tick();
    end
    fastAck = 1'b0;
    chk(fastEn, 0, "R4 fastEn off after window");
    tick();
  endtask

  task automatic tCapture(input bit v);
    windowLen = 8'd3;
    samplerIn = ~v;
    request();
    tick(); tick();
    samplerIn = v;           // sampled at the closing edge
    tick();
    chk(rndBit, v, "R7 captured value");
    chk(bitValid, 1, "R7 valid with capture");
    samplerIn = ~v; tick(); tick(); tick();
    chk(rndBit, v, "R8 rndBit holds in idle");
  endtask

  task automatic tQueue();
    windowLen = 8'd4;
    request();
    tick();
    bitReq = 1'b1; tick(); bitReq = 1'b0;   // pulse in cycle 1
    bitReq = 1'b1; tick(); bitReq = 1'b0;   // pulse in cycle 2 (last but one)
    chk(startWin, 1, "R9 first window still open");
    tick();
    chk(startWin, 0, "R9 gap cycle");
    tick();
    chk(startWin, 1, "R9 queued window opens");
    for (int i = 0; i < 4; i++) tick();
    chk(startWin, 0, "R9 second window closed");
    tick(); tick();
    chk(startWin, 0, "R9 requests collapse to one bit");
  endtask

  initial begin
    tReset();
    tWindow(4);
    tWindow(1);
    tWindow(0);
    tPrescale(3, 8);
    tPrescale(0, 4);
    tPrescale(1, 4);
    tFast();
    tCapture(1'b1);
    tCapture(1'b0);
    tQueue();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule